// File: doc/BRIEF.md
# Routed Level Interrupt Aggregator

This block collects level-sensitive interrupt sources, grouped into 32-bit words, and drives several parent interrupt lines. Software sees two registers per word: an enable register that masks or unmasks each source, and a read-only status register that shows the live source levels. Each parent line has its own routing mask for every word. A parent line is raised only by sources that are active, enabled and routed to it, so different groups of sources can go to different upstream handlers.

The enable registers do not reset to zero. They load a build-time forward mask, so chosen sources are live without any software action. A suspend input switches in a wake overlay: while it is high, the wake-capable sources are forced on in the effective enable. A separate wake output reports any active wake-capable source. When suspend drops, the value software last wrote comes back. Sources that no parent line routes are unused and can never take part.

Top module: `lvl_irq_agg`

## Requirements
- R1: Word w has its enable register at byte address 8w and its status register at 8w+4. `reg_addr[4:3]` selects the word, `reg_addr[2]` selects status, and `reg_addr[1:0]` is ignored. `reg_rdata` is registered and shows, one cycle later, the register addressed in the previous cycle.
- R2: A status read returns the current levels of that word's 32 `src_i` bits. A write to a status address changes nothing.
- R3: Reads of a word index at or above NUM_WORDS return zero, and writes to such a word have no effect.
- R4: Writing 1 to an enable bit unmasks that source and writing 0 masks it. There is no acknowledge action.
- R5: `irq_o[o]` is 1 exactly one clock after some bit, in any word, has source, effective enable and routing mask of output o all at 1. Otherwise it is 0.
- R6: The routing mask of output o for word w is `ROUTE_MASK[(o*NUM_WORDS+w)*32 +: 32]`, so the words of one output sit next to each other. Its default is all ones.
- R7: A source bit that no output routes is unused. Its enable bit reads 0 and cannot be set, and it raises neither `irq_o` nor `wake_o`.
- R8: During and after reset, each enable register holds its word of `FWD_MASK` ANDed with the used bits. `irq_o`, `wake_o` and `reg_rdata` are 0.
- R9: With WAKE_EN set, while `suspend_i` is high the effective enable (as read and as used for routing) is the saved enable ORed with `WAKE_MASK` and the used bits. Writes during suspend update the saved value, and once `suspend_i` is low the saved value alone applies.
- R10: `wake_o` is 1 one clock after `suspend_i` is high while some used `WAKE_MASK` source is active, and 0 one clock after `suspend_i` is low.
- R11: An output stays asserted for as long as its source level is held, and it clears one clock after the source drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 5 | Byte address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| src_i | input | NUM_WORDS*32 | Level interrupt sources, word w at bits [32w +: 32] |
| suspend_i | input | 1 | High while the system is suspended |
| irq_o | output | NUM_OUT | Parent interrupt lines |
| wake_o | output | 1 | Wake request during suspend |

## Verification
On every cycle the assertions check five things. A status write leaves the enables untouched. An out-of-range read returns zero. Unused enable bits stay clear. With all enables clear, no parent line rises. Without suspend, the wake line is low. The bench scenarios cover what needs a reference model or a timed sequence. These are the per-output routing under many source and enable patterns, the reset preset, and the exact one-cycle latency and hold of a level. They also include the suspend overlay and how the saved enable value comes back after suspend ends.

// File: rtl/lia_pkg.sv
package lia_pkg;

    localparam int WORD_W    = 32;
    localparam int MAX_WORDS = 4;
    localparam int ADDR_W    = 5;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic {
        REG_ENABLE = 1'b0,
        REG_STATUS = 1'b1
    } reg_kind_e;

    typedef struct packed {
        logic              wr;
        logic [ADDR_W-1:0] addr;
        word_t             data;
    } reg_req_t;

    function automatic logic [1:0] word_of(input logic [ADDR_W-1:0] a);
        return a[4:3];
    endfunction

    function automatic reg_kind_e kind_of(input logic [ADDR_W-1:0] a);
        return a[2] ? REG_STATUS : REG_ENABLE;
    endfunction

endpackage

// File: rtl/lia_regfile.sv
module lia_regfile
    import lia_pkg::*;
#(
    parameter int NUM_WORDS = 4,
    parameter bit WAKE_EN   = 1'b1,
    parameter int TOT_W     = NUM_WORDS * WORD_W,
    parameter logic [TOT_W-1:0] FWD_MASK  = '0,
    parameter logic [TOT_W-1:0] WAKE_MASK = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  reg_req_t         req,
    input  logic [TOT_W-1:0] src,
    input  logic [TOT_W-1:0] used,
    input  logic             suspend,
    output logic [TOT_W-1:0] en_eff,
    output word_t            rdata
);

    logic [TOT_W-1:0] en_saved;
    logic [TOT_W-1:0] wake_ovl;
    word_t            rd_nxt;

    assign wake_ovl = (WAKE_EN && suspend) ? (WAKE_MASK & used) : '0;
    assign en_eff   = en_saved | wake_ovl;

    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst) begin
                en_saved[w*WORD_W +: WORD_W] <= FWD_MASK[w*WORD_W +: WORD_W]
                                              & used[w*WORD_W +: WORD_W];
            end else if (req.wr && int'(word_of(req.addr)) == w
                         && kind_of(req.addr) == REG_ENABLE) begin
                en_saved[w*WORD_W +: WORD_W] <= req.data & used[w*WORD_W +: WORD_W];
            end
        end
    end

    always_comb begin
        rd_nxt = '0;
        for (int w = 0; w < NUM_WORDS; w++) begin
            if (int'(word_of(req.addr)) == w) begin
                rd_nxt = (kind_of(req.addr) == REG_STATUS) ? src[w*WORD_W +: WORD_W]
                                                           : en_eff[w*WORD_W +: WORD_W];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) rdata <= '0;
        else     rdata <= rd_nxt;
    end

    // R2: a status write leaves the saved enables untouched
    a_r2_status_write_inert: assert property (@(posedge clk) disable iff (rst)
        (req.wr && kind_of(req.addr) == REG_STATUS) |=> $stable(en_saved));

    // R3: out-of-range word reads as zero
    a_r3_range_reads_zero: assert property (@(posedge clk) disable iff (rst)
        (int'(word_of(req.addr)) >= NUM_WORDS) |=> (rdata == '0));

    // R7: unused enable bits never set
    a_r7_unused_clear: assert property (@(posedge clk) disable iff (rst)
        ((en_eff & ~used) == '0));

endmodule

// File: rtl/lia_route.sv
module lia_route
    import lia_pkg::*;
#(
    parameter int NUM_WORDS = 4,
    parameter int NUM_OUT   = 2,
    parameter int TOT_W     = NUM_WORDS * WORD_W,
    parameter logic [NUM_OUT*TOT_W-1:0] ROUTE_MASK = '1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [TOT_W-1:0]   src,
    input  logic [TOT_W-1:0]   en_eff,
    output logic [NUM_OUT-1:0] irq
);

    logic [TOT_W-1:0] live;
    assign live = src & en_eff;

    for (genvar o = 0; o < NUM_OUT; o++) begin : g_out
        always_ff @(posedge clk) begin
            if (rst) irq[o] <= 1'b0;
            else     irq[o] <= |(live & ROUTE_MASK[o*TOT_W +: TOT_W]);
        end
    end

    // R5: nothing enabled means no parent line one clock later
    a_r5_no_enable_no_irq: assert property (@(posedge clk) disable iff (rst)
        (en_eff == '0) |=> (irq == '0));

endmodule

// File: rtl/lia_wake.sv
module lia_wake
    import lia_pkg::*;
#(
    parameter int NUM_WORDS = 4,
    parameter bit WAKE_EN   = 1'b1,
    parameter int TOT_W     = NUM_WORDS * WORD_W,
    parameter logic [TOT_W-1:0] WAKE_MASK = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [TOT_W-1:0] src,
    input  logic [TOT_W-1:0] used,
    input  logic             suspend,
    output logic             wake
);

    always_ff @(posedge clk) begin
        if (rst) wake <= 1'b0;
        else     wake <= WAKE_EN && suspend && |(src & WAKE_MASK & used);
    end

    // R10: wake only follows a suspended cycle
    a_r10_wake_needs_suspend: assert property (@(posedge clk) disable iff (rst)
        (!suspend) |=> (!wake));

endmodule

// File: rtl/lvl_irq_agg.sv
module lvl_irq_agg
    import lia_pkg::*;
#(
    parameter int NUM_WORDS = 4,
    parameter int NUM_OUT   = 2,
    parameter bit WAKE_EN   = 1'b1,
    parameter logic [NUM_WORDS*WORD_W-1:0]         FWD_MASK   = '0,
    parameter logic [NUM_WORDS*WORD_W-1:0]         WAKE_MASK  = '0,
    parameter logic [NUM_OUT*NUM_WORDS*WORD_W-1:0] ROUTE_MASK = '1
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        reg_wr,
    input  logic [ADDR_W-1:0]           reg_addr,
    input  logic [WORD_W-1:0]           reg_wdata,
    output logic [WORD_W-1:0]           reg_rdata,
    input  logic [NUM_WORDS*WORD_W-1:0] src_i,
    input  logic                        suspend_i,
    output logic [NUM_OUT-1:0]          irq_o,
    output logic                        wake_o
);

    localparam int TOT_W = NUM_WORDS * WORD_W;

    function automatic logic [TOT_W-1:0] calc_used();
        logic [TOT_W-1:0] u = '0;
        for (int o = 0; o < NUM_OUT; o++) u |= ROUTE_MASK[o*TOT_W +: TOT_W];
        return u;
    endfunction

    localparam logic [TOT_W-1:0] USED = calc_used();

    reg_req_t         req;
    logic [TOT_W-1:0] en_eff;

    assign req = '{wr: reg_wr, addr: reg_addr, data: reg_wdata};

    lia_regfile #(
        .NUM_WORDS(NUM_WORDS), .WAKE_EN(WAKE_EN), .TOT_W(TOT_W),
        .FWD_MASK(FWD_MASK), .WAKE_MASK(WAKE_MASK)
    ) u_regs (
        .clk(clk), .rst(rst), .req(req), .src(src_i), .used(USED),
        .suspend(suspend_i), .en_eff(en_eff), .rdata(reg_rdata)
    );

    lia_route #(
        .NUM_WORDS(NUM_WORDS), .NUM_OUT(NUM_OUT), .TOT_W(TOT_W),
        .ROUTE_MASK(ROUTE_MASK)
    ) u_route (
        .clk(clk), .rst(rst), .src(src_i), .en_eff(en_eff), .irq(irq_o)
    );

    lia_wake #(
        .NUM_WORDS(NUM_WORDS), .WAKE_EN(WAKE_EN), .TOT_W(TOT_W),
        .WAKE_MASK(WAKE_MASK)
    ) u_wake (
        .clk(clk), .rst(rst), .src(src_i), .used(USED),
        .suspend(suspend_i), .wake(wake_o)
    );

endmodule

// File: tb/lvl_irq_agg_tb.sv
`timescale 1ns/1ps
module lvl_irq_agg_tb;

    localparam int NW  = 3;
    localparam int NO  = 2;
    localparam int TOT = NW * 32;
    localparam logic [NO*TOT-1:0] ROUTE = {32'h0000_0000, 32'h0000_FF00, 32'h00FF_0000,
                                           32'hFFFF_FFFF, 32'h0000_00FF, 32'h0000_FFFF};
    localparam logic [TOT-1:0] FWD   = {32'h8000_0001, 32'h0000_0000, 32'hFF00_00F0};
    localparam logic [TOT-1:0] WMASK = {32'h0000_0000, 32'h0001_0100, 32'h0000_0000};
    localparam logic [TOT-1:0] USED  = {32'hFFFF_FFFF, 32'h0000_FFFF, 32'h00FF_FFFF};

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           reg_wr = 1'b0;
    logic [4:0]     reg_addr = '0;
    logic [31:0]    reg_wdata = '0;
    logic [31:0]    reg_rdata;
    logic [TOT-1:0] src = '0;
    logic           susp = 1'b0;
    logic [NO-1:0]  irq_o;
    logic           wake_o;

    logic [TOT-1:0] m_en = FWD & USED;
    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    logic [31:0] seed = 32'h1234_5678;

    always #2.5 clk = ~clk;

    lvl_irq_agg #(
        .NUM_WORDS(NW), .NUM_OUT(NO), .WAKE_EN(1'b1),
        .FWD_MASK(FWD), .WAKE_MASK(WMASK), .ROUTE_MASK(ROUTE)
    ) u_dut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .src_i(src),
        .suspend_i(susp), .irq_o(irq_o), .wake_o(wake_o)
    );

    function automatic logic [31:0] lcg();
        seed = seed * 32'd1664525 + 32'd1013904223;
        return seed;
    endfunction

    function automatic logic [TOT-1:0] eff_m();
        return m_en | (susp ? (WMASK & USED) : '0);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic settle();
        repeat (2) @(negedge clk);
    endtask

    task automatic chk_outputs(input string req);
        logic [NO-1:0] e;
        for (int o = 0; o < NO; o++) e[o] = |(src & eff_m() & ROUTE[o*TOT +: TOT]);
        chk(req, 32'(irq_o), 32'(e));
        chk({req, " wake"}, 32'(wake_o), 32'(susp && |(src & WMASK & USED)));
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
        if (a[4:3] < NW && !a[2]) m_en[a[4:3]*32 +: 32] = d & USED[a[4:3]*32 +: 32];
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        @(negedge clk);
        d = reg_rdata;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        chk("R8 irq at reset", 32'(irq_o), 0);
        chk("R8 wake at reset", 32'(wake_o), 0);
        chk("R8 rdata at reset", reg_rdata, 0);
        rd(5'h00, d); chk("R8 R7 preset word0", d, 32'h0000_00F0);
        rd(5'h08, d); chk("R8 preset word1", d, 32'h0);
        rd(5'h10, d); chk("R8 preset word2", d, 32'h8000_0001);
    endtask

    task automatic t_map_status();
        logic [31:0] d;
        src = {32'hCAFE_0002, 32'h1234_ABCD, 32'h00A5_5A01};
        rd(5'h04, d); chk("R1 R2 status word0", d, 32'h00A5_5A01);
        rd(5'h0C, d); chk("R1 R2 status word1", d, 32'h1234_ABCD);
        rd(5'h17, d); chk("R1 status word2 low bits ignored", d, 32'hCAFE_0002);
        wr(5'h04, 32'hFFFF_FFFF);
        rd(5'h00, d); chk("R2 status write inert", d, 32'h0000_00F0);
        src = '0;
        settle();
        chk_outputs("R5 idle");
    endtask

    task automatic t_range();
        logic [31:0] d;
        wr(5'h18, 32'hFFFF_FFFF);
        rd(5'h18, d); chk("R3 word3 enable zero", d, 0);
        rd(5'h1C, d); chk("R3 word3 status zero", d, 0);
        rd(5'h00, d); chk("R3 write did not alias", d, 32'h0000_00F0);
    endtask

    task automatic t_level();
        settle();
        chk("R5 low before source", 32'(irq_o[0]), 0);
        @(negedge clk); src[4] = 1'b1;
        @(negedge clk); chk("R5 one-cycle latency", 32'(irq_o[0]), 1);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk); chk("R11 held while level", 32'(irq_o[0]), 1);
        end
        src[4] = 1'b0;
        @(negedge clk); chk("R11 clears after drop", 32'(irq_o[0]), 0);
    endtask

    task automatic t_mask();
        src = '0; src[5] = 1'b1;
        settle(); chk_outputs("R4 enabled source");
        chk("R4 enabled raises", 32'(irq_o[0]), 1);
        wr(5'h00, 32'h0000_00D0);
        settle(); chk("R4 masked source drops", 32'(irq_o[0]), 0);
        wr(5'h00, 32'h0000_0020);
        settle(); chk("R4 unmask raises", 32'(irq_o[0]), 1);
        src = '0;
    endtask

    task automatic t_unused();
        logic [31:0] d;
        wr(5'h00, 32'hFFFF_FFFF);
        rd(5'h00, d); chk("R7 unused enable bits read zero", d, 32'h00FF_FFFF);
        src = '0; src[31:24] = 8'hFF; src[63:48] = 16'hFFFF;
        settle(); chk("R7 unused cannot raise", 32'(irq_o), 0);
        src = '0;
    endtask

    task automatic t_route();
        wr(5'h08, 32'hFFFF_FFFF);
        wr(5'h10, 32'hFFFF_FFFF);
        src = '0; src[16] = 1'b1;
        settle(); chk("R6 word0 bit16 to out1 only", 32'(irq_o), 2);
        src = '0; src[32] = 1'b1;
        settle(); chk("R6 word1 bit0 to out0 only", 32'(irq_o), 1);
        src = '0; src[95] = 1'b1;
        settle(); chk("R6 word2 bit31 to out0 only", 32'(irq_o), 1);
        for (int i = 0; i < 40; i++) begin
            if (i % 2 == 1) wr(5'((i % 3) * 8), lcg());
            src = {lcg(), lcg(), lcg()} & {32'hFFFF_FFFF, {2{lcg()}}};
            settle();
            chk_outputs("R5 R6 random pattern");
        end
        src = '0;
    endtask

    task automatic t_wake();
        logic [31:0] d;
        wr(5'h08, 32'h0);
        @(negedge clk); susp = 1'b1;
        rd(5'h08, d); chk("R9 overlay during suspend", d, 32'h0000_0100);
        src = '0; src[40] = 1'b1;
        settle();
        chk("R10 wake asserted", 32'(wake_o), 1);
        chk_outputs("R9 overlay routes");
        wr(5'h08, 32'h0000_0001);
        rd(5'h08, d); chk("R9 write during suspend", d, 32'h0000_0101);
        @(negedge clk); susp = 1'b0;
        @(negedge clk); chk("R10 wake drops", 32'(wake_o), 0);
        rd(5'h08, d); chk("R9 saved value restored", d, 32'h0000_0001);
        settle(); chk_outputs("R9 after resume");
        src = '0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_map_status();
        t_range();
        t_level();
        t_mask();
        t_unused();
        t_route();
        t_wake();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule